// File: doc/BRIEF.md
# Click-Free Output Level Sequencer for a Stereo Audio Converter

This block runs in the master-clock domain of a stereo audio converter and decides, cycle by cycle, how loud each output channel may be. It drives two quantities: an unsigned DC bias code that brings the analog output from ground up to its quiescent level, and a gain factor that scales the signed left and right samples on their way to the modulator. Its goal is to keep transients from ever being heard when power comes up, when the clock is lost or when the clock ratio is invalid.

Start-up has two stages. First the bias code rises in equal steps at a fixed rate of master-clock cycles per code. Then a volume ramp, counted in sample strobes so that its length follows the sample rate, raises the gain linearly from zero to unity. A clock fault during the bias ramp freezes the bias where it is. A fault during the volume ramp or normal playback drops the gain to zero at once while the bias stays at the quiescent level. When the clock recovers, the volume ramp starts again from zero. Losing power returns everything to ground from any state.

Top module: `pop_mute_seq`

## Requirements
- R1: While `power_ok` is low the next clock edge puts `state_code` at OFF, `bias_code` at 0, `gain` at 0 and both sample outputs at 0, from any state.
- R2: In DC_RAMP with no fault, `bias_code` grows by one every `STEP_CYCLES` cycles, counted from entry. The edge that brings it to `BIAS_TARGET` also moves the state to MUTE. The bias never decreases while power is present.
- R3: A fault (`clk_lost` high or `clk_valid` low) in DC_RAMP moves the state to DC_HOLD, where `bias_code` holds its value and the step phase is kept. The first fault-free cycle in DC_HOLD returns the state to DC_RAMP.
- R4: From MUTE, the first fault-free cycle moves the state to SOFTSTART with gain 0. After k fault-free strobes in SOFTSTART the gain equals floor(k*65536/`SOFT_SAMPLES`). The strobe numbered `SOFT_SAMPLES` moves the state to NORMAL, where the gain holds 65536 (unity, 16 fractional bits).
- R5: A fault in SOFTSTART or NORMAL moves the state to MUTE on the next edge, with gain 0 and `bias_code` still at `BIAS_TARGET`. A later recovery restarts the volume ramp from gain 0.
- R6: Each output sample is registered one cycle after its input as (s*g + 32768) >>> 16, where s is the signed 24-bit input and g the gain of that cycle. It is 0 unless power is present and the state is SOFTSTART or NORMAL. At unity gain the output equals the input.
- R7: `state_code` encodes OFF=0, DC_RAMP=1, DC_HOLD=2, MUTE=3, SOFTSTART=4, NORMAL=5.
- R8: Sample strobes outside SOFTSTART do not change the gain. In MUTE the gain stays 0 whatever the strobe does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| power_ok | input | 1 | Supply present |
| clk_valid | input | 1 | Clock ratio currently valid |
| clk_lost | input | 1 | One-cycle loss-of-clock event |
| sample_stb | input | 1 | One pulse per sample period |
| in_left | input | 24 | Signed left sample |
| in_right | input | 24 | Signed right sample |
| bias_code | output | 12 | DC bias code, 0 = ground |
| gain | output | 17 | Gain, unity = 65536 |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| state_code | output | 3 | Sequencer state |

## Verification
The assertions assume that the fault inputs and the strobe are synchronous to the master clock and stable across each rising edge. They also assume `BIAS_TARGET` is at least one and `SOFT_SAMPLES` is no larger than 65536, so every gain step is a whole code. The bench drives all inputs one time unit after a rising edge and holds them for a full period. It keeps a small configuration (target 10, three cycles per step, twelve strobes per volume ramp), so every bias step and every gain step is visited. A per-cycle arithmetic model of the sequence supplies the expected values.

// File: rtl/pop_mute_pkg.sv
package pop_mute_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_DC_RAMP   = 3'd1,
        ST_DC_HOLD   = 3'd2,
        ST_MUTE      = 3'd3,
        ST_SOFTSTART = 3'd4,
        ST_NORMAL    = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

endpackage

// File: rtl/pop_bias_ramp.sv
module pop_bias_ramp #(
    parameter int BIAS_W      = 12,
    parameter int BIAS_TARGET = 1966,
    parameter int STEP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    output logic [BIAS_W-1:0] bias,
    output logic              done
);
    localparam int DIV_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(STEP_CYCLES - 1);
    localparam logic [BIAS_W-1:0] B_LAST   = BIAS_W'(BIAS_TARGET - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [BIAS_W-1:0] code;
    } ramp_regs_t;

    ramp_regs_t r_d, r_q;
    logic step;

    always_comb begin
        r_d  = r_q;
        step = run && (r_q.div == DIV_LAST);
        done = step && (r_q.code == B_LAST);
        if (clear) begin
            r_d.div  = '0;
            r_d.code = '0;
        end else if (run) begin
            if (step) begin
                r_d.div  = '0;
                r_d.code = r_q.code + 1'b1;
            end else begin
                r_d.div = r_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bias = r_q.code;

    a_r2_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.code <= BIAS_W'(BIAS_TARGET));

    a_r3_idle_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(r_q.code) && $stable(r_q.div));
endmodule

// File: rtl/pop_gain_ramp.sv
module pop_gain_ramp #(
    parameter int GAIN_FRAC    = 16,
    parameter int SOFT_SAMPLES = 960
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               advance,
    output logic [GAIN_FRAC:0] gain,
    output logic               done
);
    localparam int GW    = GAIN_FRAC + 1;
    localparam int UNITY = 1 << GAIN_FRAC;
    localparam int QSTEP = UNITY / SOFT_SAMPLES;
    localparam int RSTEP = UNITY % SOFT_SAMPLES;
    localparam int K_W   = $clog2(SOFT_SAMPLES + 1);
    localparam int R_W   = $clog2(SOFT_SAMPLES) + 2;
    localparam logic [K_W-1:0] K_END  = K_W'(SOFT_SAMPLES);
    localparam logic [K_W-1:0] K_LAST = K_W'(SOFT_SAMPLES - 1);
    localparam logic [R_W-1:0] R_INC  = R_W'(RSTEP);
    localparam logic [R_W-1:0] R_MOD  = R_W'(SOFT_SAMPLES);
    localparam logic [GW-1:0]  G_INC  = GW'(QSTEP);

    typedef struct packed {
        logic [K_W-1:0] cnt;
        logic [R_W-1:0] rem;
        logic [GW-1:0]  g;
    } gain_regs_t;

    gain_regs_t r_d, r_q;
    logic [R_W-1:0] rem_sum;

    always_comb begin
        r_d     = r_q;
        rem_sum = r_q.rem + R_INC;
        done    = advance && (r_q.cnt == K_LAST);
        if (clear) begin
            r_d = '0;
        end else if (advance && (r_q.cnt != K_END)) begin
            r_d.cnt = r_q.cnt + 1'b1;
            if (rem_sum >= R_MOD) begin
                r_d.rem = rem_sum - R_MOD;
                r_d.g   = r_q.g + G_INC + 1'b1;
            end else begin
                r_d.rem = rem_sum;
                r_d.g   = r_q.g + G_INC;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign gain = r_q.g;

    a_r4_gain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.g <= GW'(UNITY));

    a_r4_full_count_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cnt == K_END) |-> (r_q.g == GW'(UNITY)));

    a_r4_rising: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear) |=> (r_q.g >= $past(r_q.g)));
endmodule

// File: rtl/pop_scaler.sv
module pop_scaler #(
    parameter int SAMPLE_W  = 24,
    parameter int GAIN_FRAC = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [GAIN_FRAC:0]         gain,
    output logic signed [SAMPLE_W-1:0] scaled
);
    localparam int PW = SAMPLE_W + GAIN_FRAC + 2;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (GAIN_FRAC - 1);

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] y;
    } scale_regs_t;

    scale_regs_t r_d, r_q;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        prod    = PW'(sample) * PW'($signed({1'b0, gain}));
        shifted = (prod + HALF) >>> GAIN_FRAC;
        r_d.y   = enable ? shifted[SAMPLE_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign scaled = r_q.y;

    a_r6_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scaled == '0));

    a_r6_unity_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && gain == (GAIN_FRAC+1)'(1 << GAIN_FRAC)) |=> (scaled == $past(sample)));
endmodule

// File: rtl/pop_mute_seq.sv
module pop_mute_seq
    import pop_mute_pkg::*;
#(
    parameter int BIAS_W       = 12,
    parameter int BIAS_TARGET  = 1966,
    parameter int STEP_CYCLES  = 4,
    parameter int SOFT_SAMPLES = 960,
    parameter int SAMPLE_W     = 24,
    parameter int GAIN_FRAC    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       power_ok,
    input  logic                       clk_valid,
    input  logic                       clk_lost,
    input  logic                       sample_stb,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    output logic [BIAS_W-1:0]          bias_code,
    output logic [GAIN_FRAC:0]         gain,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right,
    output logic [2:0]                 state_code
);
    localparam int GW = GAIN_FRAC + 1;
    localparam logic [GW-1:0]     G_UNITY = GW'(1 << GAIN_FRAC);
    localparam logic [BIAS_W-1:0] B_TGT   = BIAS_W'(BIAS_TARGET);

    seq_regs_t s_d, s_q;
    logic fault;
    logic b_clear, b_run, b_done;
    logic g_clear, g_adv, g_done;
    logic play_en;

    always_comb begin
        s_d     = s_q;
        fault   = clk_lost || !clk_valid;
        b_clear = 1'b0;
        b_run   = 1'b0;
        g_clear = 1'b0;
        g_adv   = 1'b0;
        if (!power_ok) begin
            s_d.st  = ST_OFF;
            b_clear = 1'b1;
            g_clear = 1'b1;
        end else begin
            unique case (s_q.st)
                ST_OFF: begin
                    s_d.st  = ST_DC_RAMP;
                    b_clear = 1'b1;
                    g_clear = 1'b1;
                end
                ST_DC_RAMP: begin
                    if (fault) begin
                        s_d.st = ST_DC_HOLD;
                    end else begin
                        b_run = 1'b1;
                        if (b_done) s_d.st = ST_MUTE;
                    end
                end
                ST_DC_HOLD: begin
                    if (!fault) s_d.st = ST_DC_RAMP;
                end
                ST_MUTE: begin
                    g_clear = 1'b1;
                    if (!fault) s_d.st = ST_SOFTSTART;
                end
                ST_SOFTSTART: begin
                    if (fault) begin
                        s_d.st  = ST_MUTE;
                        g_clear = 1'b1;
                    end else begin
                        g_adv = sample_stb;
                        if (g_done) s_d.st = ST_NORMAL;
                    end
                end
                ST_NORMAL: begin
                    if (fault) begin
                        s_d.st  = ST_MUTE;
                        g_clear = 1'b1;
                    end
                end
                default: begin
                    s_d.st  = ST_OFF;
                    b_clear = 1'b1;
                    g_clear = 1'b1;
                end
            endcase
        end
        play_en = power_ok && ((s_q.st == ST_SOFTSTART) || (s_q.st == ST_NORMAL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_OFF};
        else        s_q <= s_d;
    end

    pop_bias_ramp #(
        .BIAS_W(BIAS_W), .BIAS_TARGET(BIAS_TARGET), .STEP_CYCLES(STEP_CYCLES)
    ) u_bias (
        .clk(clk), .rst_n(rst_n), .clear(b_clear), .run(b_run),
        .bias(bias_code), .done(b_done)
    );

    pop_gain_ramp #(
        .GAIN_FRAC(GAIN_FRAC), .SOFT_SAMPLES(SOFT_SAMPLES)
    ) u_gain (
        .clk(clk), .rst_n(rst_n), .clear(g_clear), .advance(g_adv),
        .gain(gain), .done(g_done)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic signed [SAMPLE_W-1:0] x_in;
        logic signed [SAMPLE_W-1:0] x_out;
        assign x_in = (ch == 0) ? in_left : in_right;
        pop_scaler #(
            .SAMPLE_W(SAMPLE_W), .GAIN_FRAC(GAIN_FRAC)
        ) u_scale (
            .clk(clk), .rst_n(rst_n), .enable(play_en),
            .sample(x_in), .gain(gain), .scaled(x_out)
        );
    end

    assign out_left   = g_chan[0].x_out;
    assign out_right  = g_chan[1].x_out;
    assign state_code = s_q.st;

    a_r1_power_loss_grounds: assert property (@(posedge clk) disable iff (!rst_n)
        !power_ok |=> (s_q.st == ST_OFF) && (bias_code == '0) && (gain == '0));

    a_r3_hold_freezes_bias: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DC_HOLD && power_ok) |=> $stable(bias_code));

    a_r2_ramp_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DC_RAMP && power_ok) |=> (bias_code >= $past(bias_code)));

    a_r5_mute_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_MUTE) |-> (gain == '0) && (bias_code == B_TGT));

    a_r5_fault_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        (power_ok && fault && (s_q.st == ST_NORMAL || s_q.st == ST_SOFTSTART))
            |=> (s_q.st == ST_MUTE));

    a_r4_normal_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_NORMAL) |-> (gain == G_UNITY));

    a_r7_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st inside {ST_OFF, ST_DC_RAMP, ST_DC_HOLD, ST_MUTE, ST_SOFTSTART, ST_NORMAL});
endmodule

// File: tb/pop_mute_seq_tb.sv
module pop_mute_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TGT  = 10;
    localparam int STEP = 3;
    localparam int NS   = 12;
    localparam int UNITY = 65536;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic power_ok = 1'b0, clk_valid = 1'b0, clk_lost = 1'b0, sample_stb = 1'b0;
    logic signed [23:0] in_left = '0, in_right = '0;
    logic [11:0] bias_code;
    logic [16:0] gain;
    logic signed [23:0] out_left, out_right;
    logic [2:0] state_code;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    int est = 0, eb = 0, eph = 0, ek = 0;
    longint eol = 0, eor = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pop_mute_seq #(
        .BIAS_TARGET(TGT), .STEP_CYCLES(STEP), .SOFT_SAMPLES(NS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .power_ok(power_ok), .clk_valid(clk_valid),
        .clk_lost(clk_lost), .sample_stb(sample_stb), .in_left(in_left),
        .in_right(in_right), .bias_code(bias_code), .gain(gain),
        .out_left(out_left), .out_right(out_right), .state_code(state_code)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint scale(input longint s, input longint g);
        longint p;
        p = s * g + 32768;
        return p >>> 16;
    endfunction

    function automatic longint exp_gain();
        return (longint'(ek) * UNITY) / NS;
    endfunction

    // one clock: advance the reference model, then compare all outputs
    task automatic tick();
        bit fault;
        fault = clk_lost || !clk_valid;
        if (power_ok && (est == 4 || est == 5)) begin
            eol = scale(in_left, exp_gain());
            eor = scale(in_right, exp_gain());
        end else begin
            eol = 0; eor = 0;
        end
        if (!power_ok) begin
            est = 0; eb = 0; eph = 0; ek = 0;
        end else begin
            case (est)
                0: begin est = 1; eb = 0; eph = 0; ek = 0; end
                1: if (fault) est = 2;
                   else begin
                       eph++;
                       if (eph == STEP) begin
                           eph = 0; eb++;
                           if (eb == TGT) est = 3;
                       end
                   end
                2: if (!fault) est = 1;
                3: if (!fault) begin est = 4; ek = 0; end
                4: if (fault) begin est = 3; ek = 0; end
                   else if (sample_stb) begin
                       ek++;
                       if (ek == NS) est = 5;
                   end
                5: if (fault) begin est = 3; ek = 0; end
                default: est = 0;
            endcase
        end
        @(posedge clk);
        #1;
        check("R7 state", state_code, est);
        check("R2 bias", bias_code, eb);
        check("R4 gain", gain, exp_gain());
        check("R6 left", out_left, eol);
        check("R6 right", out_right, eor);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic play(input int cycles, input int base);
        for (int i = 0; i < cycles; i++) begin
            sample_stb = (i % 3 == 2);
            in_left  = 24'(base + i * 376913);
            in_right = 24'(-(base * 7) + i * 91);
            tick();
        end
        sample_stb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 reset state", state_code, 0);
        check("R1 reset bias", bias_code, 0);
        check("R1 reset out", out_left, 0);
        rst_n = 1'b1;
        run(3);
        check("R1 unpowered stays off", state_code, 0);

        // R2: power up, partial ramp
        power_ok = 1'b1; clk_valid = 1'b1;
        run(8);
        // R3: freeze by invalid ratio then by a single lost pulse
        clk_valid = 1'b0;
        run(5);
        check("R3 held", state_code, 2);
        clk_valid = 1'b1;
        run(4);
        clk_lost = 1'b1; tick(); clk_lost = 1'b0;
        check("R3 hold after pulse", state_code, 2);
        run(TGT * STEP + 5);
        check("R2 reached quiescent", bias_code, TGT);

        // R8: strobes in MUTE with invalid clock have no effect
        clk_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin sample_stb = i[0]; tick(); end
        sample_stb = 1'b0;
        check("R8 mute gain", gain, 0);
        check("R8 mute state", state_code, 3);

        // R4: full soft start, every gain step
        clk_valid = 1'b1;
        play(3 * NS + 6, 1234567);
        check("R4 normal", state_code, 5);
        check("R4 unity", gain, UNITY);

        // R6: extreme samples at unity
        in_left = 24'sh7FFFFF; in_right = 24'sh800000; tick();
        check("R6 max pass", out_left, 24'sh7FFFFF);
        check("R6 min pass", out_right, -8388608);

        // R5: lost pulse in NORMAL, restart partially, fault in soft start
        clk_lost = 1'b1; tick(); clk_lost = 1'b0;
        check("R5 muted", state_code, 3);
        check("R5 gain zero", gain, 0);
        check("R5 bias kept", bias_code, TGT);
        play(14, -4000000);
        clk_valid = 1'b0; tick();
        check("R5 softstart fault", state_code, 3);
        clk_valid = 1'b1;
        play(3 * NS + 3, 8000000);

        // R1: power loss from NORMAL
        power_ok = 1'b0; tick();
        check("R1 power loss", state_code, 0);
        check("R1 power loss bias", bias_code, 0);
        run(2);

        // R3: power up with no valid clock sits in hold at ground
        clk_valid = 1'b0; power_ok = 1'b1;
        run(6);
        check("R3 hold at ground", bias_code, 0);
        clk_valid = 1'b1;
        run(TGT * STEP + 4);
        play(3 * NS + 3, -77);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule